// File: doc/BRIEF.md
# Integer Multiply-Accumulate Execution Unit

This unit executes the integer multiply and multiply-accumulate group of a 64-bit RISC pipeline. It keeps a 64-bit running accumulator split across two architectural registers. The high half of the accumulator sits in the low word of HI and the low half sits in the low word of LO. Each accepted instruction takes the low 32 bits of its two source operands and forms a 64-bit signed or unsigned product. The product either replaces the accumulator or is added to it.

Most variants also return one half of the new accumulator to a general register, sign-extended to 64 bits, through a write-back port that carries the destination index. An accumulate-only variant updates HI/LO and returns nothing. A doubleword accumulate variant writes the whole 64-bit sum into LO and leaves HI alone.

Issue uses a valid/ready handshake. Every accepted instruction completes exactly two cycles later, and the unit accepts a new instruction every cycle. A back-to-back accumulate sees the result of the instruction issued just before it, because the accumulator is kept inside the unit and fed forward.

Top module: `mac_unit`

## Requirements
- R1: The accumulator is {HI[31:0], LO[31:0]}. The plain multiply codes in instruction bits [10:6] replace it with the product: 00100 (signed, return low), 00101 (unsigned, return low), 01100 (signed, return high) and 01101 (unsigned, return high). The group is recognised by bits [31:26] = 000000 and bits [5:0] = 101000.
- R2: Only bits [31:0] of each source operand are used. Bit 0 of the sub-code clear means a signed 32x32 product, and set means an unsigned one; the full 64-bit product is kept either way.
- R3: The accumulate codes add the product to the current accumulator modulo 2^64: 00010 (signed, return low), 00011 (unsigned, return low), 01010 (signed, return high) and 01011 (unsigned, return high).
- R4: Codes with bit 3 clear return the new accumulator bits [31:0], and codes with bit 3 set return bits [63:32]. Either half is sign-extended to 64 bits on wb_data, with the destination index taken from instruction bits [15:11].
- R5: Sub-code 00000 with function 101000 and destination field 0 performs a signed multiply-accumulate and asserts no write-back.
- R6: Function 101001, with bits [15:11] and [10:6] both zero, adds the signed product to the accumulator and writes the full 64-bit sum into LO. HI is left unchanged and no write-back is made.
- R7: Every update other than the one in R6 writes only bits [31:0] of HI and LO; bits [63:32] of each keep their previous value.
- R8: An instruction accepted at a rising edge produces done, and any write-back or HI/LO change, after the second rising edge. Instructions issued on consecutive cycles each see the accumulator left by the one before.
- R9: A write-back to index 0 is suppressed (wb_en stays low), while HI/LO are still updated.
- R10: Any accepted instruction outside the recognised encodings pulses reserved with done, makes no write-back, and leaves HI and LO unchanged.
- R11: While rst_n is low, HI and LO read zero and in_ready, done, wb_en and reserved are low. in_ready is high from the first rising edge after release.
- R12: When in_valid is low, nothing is accepted: done stays low and HI/LO do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Instruction offered this cycle |
| in_ready | output | 1 | Unit can accept an instruction |
| in_instr | input | 32 | Decoded instruction word |
| in_rs | input | 64 | First source register value |
| in_rt | input | 64 | Second source register value |
| wb_en | output | 1 | General register write-back enable |
| wb_idx | output | 5 | Write-back destination index |
| wb_data | output | 64 | Sign-extended accumulator half |
| done | output | 1 | One-cycle pulse per completed instruction |
| reserved | output | 1 | Completed instruction was not recognised |
| hi | output | 64 | HI register |
| lo | output | 64 | LO register |

## Verification
A chain of vectors runs every sub-code, each building on the accumulator left by the vector before it. Its operands are chosen so the cases can be told apart: the most negative value squared, all-ones squared, a signed -1 against an unsigned 0xFFFFFFFF, and an accumulate that wraps past 2^64. Junk in the upper operand bits shows that only the low words are used. A doubleword accumulate followed by a 32-bit accumulate shows whether the upper word of LO is kept, and the rd=0 and reserved codes show whether write-back and HI/LO are guarded. Three instructions issued back to back check the forwarding path, and a reset in the middle of a run together with an idle cycle carrying a held instruction word check that nothing is started or kept.

// File: rtl/mac_pkg.sv
package mac_pkg;

  localparam int INSTR_W = 32;

  localparam logic [5:0] MAJOR_GROUP = 6'b000000;
  localparam logic [5:0] FN_ACC32    = 6'b101000;
  localparam logic [5:0] FN_ACC64    = 6'b101001;

  typedef enum logic [4:0] {
    SEL_ACC_QUIET  = 5'b00000,
    SEL_ACC_LO_S   = 5'b00010,
    SEL_ACC_LO_U   = 5'b00011,
    SEL_MUL_LO_S   = 5'b00100,
    SEL_MUL_LO_U   = 5'b00101,
    SEL_ACC_HI_S   = 5'b01010,
    SEL_ACC_HI_U   = 5'b01011,
    SEL_MUL_HI_S   = 5'b01100,
    SEL_MUL_HI_U   = 5'b01101
  } mac_sel_e;

  typedef struct packed {
    logic legal;
    logic is_signed;
    logic accumulate;
    logic wb_high;
    logic wb_req;
    logic full_lo;
  } mac_ctrl_t;

endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [INSTR_W-1:0] instr,
  output mac_ctrl_t          ctrl,
  output logic [IDX_W-1:0]   dst
);

  logic [5:0] major;
  logic [5:0] fn;
  logic [4:0] sel;

  assign major = instr[31:26];
  assign fn    = instr[5:0];
  assign sel   = instr[10:6];
  assign dst   = instr[15:11];

  always_comb begin
    ctrl = '0;
    if (major == MAJOR_GROUP && fn == FN_ACC32) begin
      case (sel)
        SEL_ACC_QUIET: begin
          if (dst == '0) begin
            ctrl.legal      = 1'b1;
            ctrl.is_signed  = 1'b1;
            ctrl.accumulate = 1'b1;
          end
        end
        SEL_ACC_LO_S, SEL_ACC_LO_U, SEL_MUL_LO_S, SEL_MUL_LO_U,
        SEL_ACC_HI_S, SEL_ACC_HI_U, SEL_MUL_HI_S, SEL_MUL_HI_U: begin
          ctrl.legal      = 1'b1;
          ctrl.is_signed  = ~sel[0];
          ctrl.accumulate = ~sel[2];
          ctrl.wb_high    = sel[3];
          ctrl.wb_req     = 1'b1;
        end
        default: ctrl = '0;
      endcase
    end else if (major == MAJOR_GROUP && fn == FN_ACC64 &&
                 dst == '0 && sel == 5'b00000) begin
      ctrl.legal      = 1'b1;
      ctrl.is_signed  = 1'b1;
      ctrl.accumulate = 1'b1;
      ctrl.full_lo    = 1'b1;
    end
  end

endmodule

// File: rtl/mac_mul_stage.sv
module mac_mul_stage
  import mac_pkg::*;
#(
  parameter int OPW   = 32,
  parameter int IDX_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  mac_ctrl_t          ctrl,
  input  logic [IDX_W-1:0]   dst,
  input  logic [OPW-1:0]     op_a,
  input  logic [OPW-1:0]     op_b,
  output logic               s1_valid,
  output mac_ctrl_t          s1_ctrl,
  output logic [IDX_W-1:0]   s1_dst,
  output logic [2*OPW-1:0]   s1_prod
);

  localparam int EXT_W  = OPW + 1;
  localparam int FULL_W = 2 * EXT_W;
  localparam int PROD_W = 2 * OPW;

  logic signed [EXT_W-1:0]  ext_a, ext_b;
  logic signed [FULL_W-1:0] wide_a, wide_b, prod_full;

  logic               valid_d;
  mac_ctrl_t          ctrl_d;
  logic [IDX_W-1:0]   dst_d;
  logic [PROD_W-1:0]  prod_d;

  // One extra bit lets a single signed multiplier cover both signednesses.
  always_comb begin
    ext_a     = {ctrl.is_signed & op_a[OPW-1], op_a};
    ext_b     = {ctrl.is_signed & op_b[OPW-1], op_b};
    wide_a    = {{EXT_W{ext_a[EXT_W-1]}}, ext_a};
    wide_b    = {{EXT_W{ext_b[EXT_W-1]}}, ext_b};
    prod_full = wide_a * wide_b;
  end

  always_comb begin
    valid_d = fire;
    ctrl_d  = s1_ctrl;
    dst_d   = s1_dst;
    prod_d  = s1_prod;
    if (fire) begin
      ctrl_d = ctrl;
      dst_d  = dst;
      prod_d = prod_full[PROD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_ctrl  <= '0;
      s1_dst   <= '0;
      s1_prod  <= '0;
    end else begin
      s1_valid <= valid_d;
      s1_ctrl  <= ctrl_d;
      s1_dst   <= dst_d;
      s1_prod  <= prod_d;
    end
  end

endmodule

// File: rtl/mac_acc_stage.sv
module mac_acc_stage
  import mac_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_valid,
  input  mac_ctrl_t         s1_ctrl,
  input  logic [IDX_W-1:0]  s1_dst,
  input  logic [XLEN-1:0]   s1_prod,
  output logic [XLEN-1:0]   hi_q,
  output logic [XLEN-1:0]   lo_q,
  output logic              wb_en_q,
  output logic [IDX_W-1:0]  wb_idx_q,
  output logic [XLEN-1:0]   wb_data_q,
  output logic              done_q,
  output logic              rsv_q
);

  localparam int HW = XLEN / 2;

  logic [XLEN-1:0] acc_q, acc_d;
  logic [XLEN-1:0] hi_d, lo_d;
  logic [XLEN-1:0] base, sum;
  logic [HW-1:0]   half;
  logic            upd;
  logic            wb_en_d, done_d, rsv_d;
  logic [IDX_W-1:0] wb_idx_d;
  logic [XLEN-1:0] wb_data_d;

  // acc_q mirrors {hi[HW-1:0], lo[HW-1:0]} and feeds the next instruction directly.
  always_comb begin
    upd  = s1_valid & s1_ctrl.legal;
    base = s1_ctrl.accumulate ? acc_q : '0;
    sum  = base + s1_prod;
    half = s1_ctrl.wb_high ? sum[XLEN-1:HW] : sum[HW-1:0];
  end

  always_comb begin
    hi_d  = hi_q;
    lo_d  = lo_q;
    acc_d = acc_q;
    if (upd) begin
      if (s1_ctrl.full_lo) begin
        lo_d  = sum;
        acc_d = {acc_q[XLEN-1:HW], sum[HW-1:0]};
      end else begin
        hi_d  = {hi_q[XLEN-1:HW], sum[XLEN-1:HW]};
        lo_d  = {lo_q[XLEN-1:HW], sum[HW-1:0]};
        acc_d = sum;
      end
    end
  end

  always_comb begin
    done_d    = s1_valid;
    rsv_d     = s1_valid & ~s1_ctrl.legal;
    wb_en_d   = upd & s1_ctrl.wb_req & (s1_dst != '0);
    wb_idx_d  = wb_idx_q;
    wb_data_d = wb_data_q;
    if (upd && s1_ctrl.wb_req) begin
      wb_idx_d  = s1_dst;
      wb_data_d = {{(XLEN-HW){half[HW-1]}}, half};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      acc_q <= '0;
    end else if (upd) begin
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_en_q   <= 1'b0;
      wb_idx_q  <= '0;
      wb_data_q <= '0;
      done_q    <= 1'b0;
      rsv_q     <= 1'b0;
    end else begin
      wb_en_q   <= wb_en_d;
      wb_idx_q  <= wb_idx_d;
      wb_data_q <= wb_data_d;
      done_q    <= done_d;
      rsv_q     <= rsv_d;
    end
  end

endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_instr,
  input  logic [XLEN-1:0]   in_rs,
  input  logic [XLEN-1:0]   in_rt,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [XLEN-1:0]   wb_data,
  output logic              done,
  output logic              reserved,
  output logic [XLEN-1:0]   hi,
  output logic [XLEN-1:0]   lo
);

  localparam int OPW = XLEN / 2;

  logic             rdy_q, rdy_d;
  logic             fire;
  mac_ctrl_t        dec_ctrl;
  logic [IDX_W-1:0] dec_dst;
  logic             s1_valid;
  mac_ctrl_t        s1_ctrl;
  logic [IDX_W-1:0] s1_dst;
  logic [XLEN-1:0]  s1_prod;

  always_comb begin
    rdy_d = 1'b1;
    fire  = in_valid & rdy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= rdy_d;
  end

  assign in_ready = rdy_q;

  mac_decode #(.IDX_W(IDX_W)) u_dec (
    .instr (in_instr),
    .ctrl  (dec_ctrl),
    .dst   (dec_dst)
  );

  mac_mul_stage #(.OPW(OPW), .IDX_W(IDX_W)) u_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .ctrl     (dec_ctrl),
    .dst      (dec_dst),
    .op_a     (in_rs[OPW-1:0]),
    .op_b     (in_rt[OPW-1:0]),
    .s1_valid (s1_valid),
    .s1_ctrl  (s1_ctrl),
    .s1_dst   (s1_dst),
    .s1_prod  (s1_prod)
  );

  mac_acc_stage #(.XLEN(XLEN), .IDX_W(IDX_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_valid  (s1_valid),
    .s1_ctrl   (s1_ctrl),
    .s1_dst    (s1_dst),
    .s1_prod   (s1_prod),
    .hi_q      (hi),
    .lo_q      (lo),
    .wb_en_q   (wb_en),
    .wb_idx_q  (wb_idx),
    .wb_data_q (wb_data),
    .done_q    (done),
    .rsv_q     (reserved)
  );

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int XLEN  = 64,
  parameter int IDX_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [31:0]       in_instr,
  input logic [XLEN-1:0]   in_rs,
  input logic [XLEN-1:0]   in_rt,
  input logic              wb_en,
  input logic [IDX_W-1:0]  wb_idx,
  input logic [XLEN-1:0]   wb_data,
  input logic              done,
  input logic              reserved,
  input logic [XLEN-1:0]   hi,
  input logic [XLEN-1:0]   lo
);

  localparam int HW = XLEN / 2;

  assert_wb_sext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_data[XLEN-1:HW] == {HW{wb_data[HW-1]}}));

  assert_no_zero_dst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_idx != '0));

  assert_reserved_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reserved |-> (!wb_en && $stable(hi) && $stable(lo)));

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready, 2) |-> done);

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(hi) && $stable(lo) && !wb_en && !reserved));

  assert_hi_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(hi[XLEN-1:HW]));

endmodule

bind mac_unit mac_unit_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_mac_unit.sv
`timescale 1ns/1ps
module test_mac_unit;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_instr;
  logic [63:0] in_rs, in_rt;
  logic        wb_en;
  logic [4:0]  wb_idx;
  logic [63:0] wb_data;
  logic        done;
  logic        reserved;
  logic [63:0] hi, lo;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  mac_unit i_mac_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_rs(in_rs), .in_rt(in_rt),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .done(done), .reserved(reserved), .hi(hi), .lo(lo)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] enc(input logic [4:0] sel, input logic [4:0] rd,
                                      input logic [5:0] fn);
    return {6'b000000, 5'd1, 5'd2, rd, sel, fn};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // Stimulus and expected results, one instruction each, chained through the accumulator.
  localparam int NV = 14;
  localparam logic [4:0]  T_SEL [NV] = '{5'b00100, 5'b00101, 5'b01100, 5'b01101, 5'b00010,
    5'b00011, 5'b01010, 5'b01011, 5'b00000, 5'b00010, 5'b00000, 5'b01010, 5'b00111, 5'b00010};
  localparam logic [4:0]  T_RD  [NV] = '{5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9, 5'd10,
    5'd0, 5'd0, 5'd0, 5'd11, 5'd12, 5'd13};
  localparam logic [5:0]  T_FN  [NV] = '{6'h28, 6'h28, 6'h28, 6'h28, 6'h28, 6'h28, 6'h28,
    6'h28, 6'h28, 6'h28, 6'h29, 6'h28, 6'h28, 6'h28};
  localparam logic [63:0] T_A   [NV] = '{64'hDEAD0000_00000007, 64'h12345678_00000007,
    64'h00000000_80000000, 64'hFFFFFFFF_FFFFFFFF, 64'h00000000_00000002, 64'h00000000_FFFFFFFF,
    64'h00000000_FFFFFFFF, 64'h00000000_80000000, 64'h00000000_FFFFFFFE, 64'h00000000_00000001,
    64'h00000000_7FFFFFFF, 64'h0, 64'h00000000_00000005, 64'h00000000_00000001};
  localparam logic [63:0] T_B   [NV] = '{64'h00000000_FFFFFFFD, 64'hABCD0000_FFFFFFFD,
    64'h00000000_80000000, 64'h00000000_FFFFFFFF, 64'h00000000_00000003, 64'h00000000_00000002,
    64'h00000000_FFFFFFFF, 64'h00000000_00000004, 64'h00000000_00000003, 64'h00000000_00000001,
    64'h00000000_00000002, 64'h0, 64'h00000000_00000005, 64'h00000000_00000001};
  localparam logic        T_EN  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
    1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [63:0] T_WB  [NV] = '{64'hFFFFFFFF_FFFFFFEB, 64'hFFFFFFFF_FFFFFFEB,
    64'h00000000_40000000, 64'hFFFFFFFF_FFFFFFFE, 64'h7, 64'h5, 64'h0, 64'h2,
    64'h0, 64'h0, 64'h0, 64'h2, 64'h0, 64'h0};
  localparam logic [63:0] T_HI  [NV] = '{64'hFFFFFFFF, 64'h6, 64'h40000000, 64'hFFFFFFFE,
    64'hFFFFFFFE, 64'h0, 64'h0, 64'h2, 64'h2, 64'h2, 64'h2, 64'h2, 64'h2, 64'h3};
  localparam logic [63:0] T_LO  [NV] = '{64'hFFFFFFEB, 64'hFFFFFFEB, 64'h0, 64'h1, 64'h7,
    64'h5, 64'h6, 64'h6, 64'h0, 64'h1, 64'h00000002_FFFFFFFF, 64'h00000002_FFFFFFFF,
    64'h00000002_FFFFFFFF, 64'h00000002_00000000};
  localparam logic        T_RSV [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_instr = '0;
    in_rs    = '0;
    in_rt    = '0;
    repeat (3) @(negedge clk);

    // R11: reset state
    chk("R11 hi in reset", hi, 64'h0);
    chk("R11 lo in reset", lo, 64'h0);
    chk("R11 ready in reset", {63'h0, in_ready}, 64'h0);
    chk("R11 outputs quiet", {60'h0, done, wb_en, reserved, 1'b0}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ready after release", {63'h0, in_ready}, 64'h1);

    // R1..R7, R9, R10: chained vector table
    for (int i = 0; i < NV; i++) begin
      in_instr = enc(T_SEL[i], T_RD[i], T_FN[i]);
      in_rs    = T_A[i];
      in_rt    = T_B[i];
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk($sformatf("R8 no early done v%0d", i), {63'h0, done}, 64'h0);
      @(negedge clk);
      chk($sformatf("R8 done v%0d", i), {63'h0, done}, 64'h1);
      chk($sformatf("R9 R5 R10 wb_en v%0d", i), {63'h0, wb_en}, {63'h0, T_EN[i]});
      if (T_EN[i]) begin
        chk($sformatf("R4 wb_data v%0d", i), wb_data, T_WB[i]);
        chk($sformatf("R4 wb_idx v%0d", i), {59'h0, wb_idx}, {59'h0, T_RD[i]});
      end
      chk($sformatf("R1 R2 R3 R6 hi v%0d", i), hi, T_HI[i]);
      chk($sformatf("R1 R3 R6 R7 lo v%0d", i), lo, T_LO[i]);
      chk($sformatf("R10 reserved v%0d", i), {63'h0, reserved}, {63'h0, T_RSV[i]});
    end

    // R12: held instruction with in_valid low is not taken
    in_instr = enc(5'b00100, 5'd9, 6'h28);
    in_rs    = 64'h7;
    in_rt    = 64'h7;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 no done while idle", {63'h0, done}, 64'h0);
    chk("R12 hi held while idle", hi, 64'h3);
    chk("R12 lo held while idle", lo, 64'h00000002_00000000);

    // R10: wrong major opcode is reserved
    in_instr = {6'b000001, 5'd1, 5'd2, 5'd4, 5'b00100, 6'h28};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10 bad major flagged", {62'h0, done, reserved}, 64'h3);
    chk("R10 bad major hi kept", hi, 64'h3);

    // R8: three back-to-back instructions through the forwarded accumulator
    in_instr = enc(5'b00100, 5'd1, 6'h28); in_rs = 64'd3; in_rt = 64'd4; in_valid = 1'b1;
    @(negedge clk);
    in_instr = enc(5'b00010, 5'd2, 6'h28); in_rs = 64'd5; in_rt = 64'd6;
    @(negedge clk);
    chk("R8 b2b first wb", wb_data, 64'd12);
    in_instr = enc(5'b01010, 5'd3, 6'h28); in_rs = 64'h10000; in_rt = 64'h10000;
    @(negedge clk);
    chk("R8 b2b second wb", wb_data, 64'd42);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R8 b2b third wb", wb_data, 64'd1);
    chk("R8 b2b third idx", {59'h0, wb_idx}, 64'd3);
    chk("R8 b2b hi", hi, 64'h1);
    chk("R8 R7 b2b lo", lo, 64'h00000002_0000002A);

    // R11: reset in the middle of a run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 mid reset hi", hi, 64'h0);
    chk("R11 mid reset lo", lo, 64'h0);
    chk("R11 mid reset ready", {63'h0, in_ready}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    in_instr = enc(5'b00010, 5'd5, 6'h28); in_rs = 64'd2; in_rt = 64'd2; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R11 R3 accumulate from zero after reset", wb_data, 64'd4);

    finished = 1;
    summary();
    $finish;
  end

endmodule